// File: doc/BRIEF.md
# Depth-Chain Ownership Controller

This block is the control slice that lets several FIFO instances be chained into one deeper queue. Each instance in the chain carries one copy. The copy keeps two ownership tokens: one for the write role and one for the read role. An instance may accept a parallel write only while it holds the write token, and may deliver a word only while it holds the read token. All the instances connect in a ring, each one's hand-off output feeding the next one's hand-off input. Data therefore fills the first instance, spills into the second, and so on, and it drains in the same order.

A strap input marks the instance that starts the chain. After reset, only that instance owns both roles. When a permitted write lands in the last physical location of the local array, the write token leaves the instance. The same happens to the read token when a permitted read takes the last location. Each departure shows as a one-cycle pulse on the hand-off output. Both departures share one wire, so the receiver cannot tell which role a pulse carries. A received pulse therefore arms both roles. The next local write, or the next local read, then claims the matching role and is told to start at location zero. When both roles leave in the same cycle, their pulses go out in two consecutive cycles.

The local pointers, the storage array and the composite full and empty flags sit outside this block. Retransmit and the half-full output have no meaning in a chain, so this block offers neither.

Top module: `depth_chain_ctrl`

## Requirements
- R1: While `rst_n` is low, `wr_en`, `rd_en`, `wr_jump`, `rd_jump`, `wr_tok`, `rd_tok` and `xout` are all 0. The same holds for the two clock edges that release the internal reset.
- R2: On the third rising edge after `rst_n` goes high, both tokens are set if `first_n` is 0 and cleared if `first_n` is 1.
- R3: While the write token is held, `wr_en` follows `wr_req` in the same cycle. `rd_en` follows `rd_req` in the same way while the read token is held.
- R4: A cycle with `wr_en` and `wr_last` both 1 clears `wr_tok` at the next edge. `xout` is then 1 for the cycle after that edge.
- R5: A cycle with `rd_en` and `rd_last` both 1 clears `rd_tok` at the next edge. `xout` is then 1 for the cycle after that edge.
- R6: If write and read hand-offs fall in the same cycle, `xout` is 1 for two consecutive cycles: the write pulse first, then the read pulse.
- R7: A cycle with `xin` at 1 arms both roles. The first later request for a role whose token is not held is enabled, with its jump output (`wr_jump` or `rd_jump`) at 1 in that cycle. The token is then held from the next edge, unless that same request also carries its last-location flag.
- R8: A request for a role whose token is neither held nor armed gives no enable and no jump, and it leaves the token cleared.
- R9: `wr_last` and `rd_last` have no effect on tokens or `xout` unless they come with an enabled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| first_n | input | 1 | Strap, 0 on the instance that starts the chain |
| xin | input | 1 | Hand-off pulse from the previous instance |
| wr_req | input | 1 | Write requested this cycle |
| wr_last | input | 1 | Local write pointer sits at the last physical location |
| rd_req | input | 1 | Read requested this cycle |
| rd_last | input | 1 | Local read pointer sits at the last physical location |
| wr_en | output | 1 | Gated write enable |
| rd_en | output | 1 | Gated read enable |
| wr_jump | output | 1 | This write claims the write role; the write pointer loads location zero |
| rd_jump | output | 1 | This read claims the read role; the read pointer loads location zero |
| wr_tok | output | 1 | Write token held |
| rd_tok | output | 1 | Read token held |
| xout | output | 1 | Hand-off pulse to the next instance |

## Verification
The bench aims at the edges where ownership moves. It drives a write hand-off and a read hand-off in the same cycle; a merger that dropped or merged one of them would show a single pulse where two are due. It regains a role through an armed pulse and hands it off again in the same cycle, which catches a token update that lets the claim win over the departure. It sends requests and last-location flags to an instance with no token and no arm, which would expose enables or pulses that leak without ownership. It also repeats reset with the strap both ways, so a controller that ignored the strap would hold tokens on every instance.

// File: rtl/depth_chain_pkg.sv
package depth_chain_pkg;
  typedef enum logic [0:0] {
    ROLE_WR = 1'b0,
    ROLE_RD = 1'b1
  } role_e;

  localparam int NUM_ROLES = 2;
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/depth_chain_rst_sync.sv
module depth_chain_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/depth_chain_role.sv
// Ownership of one role (write or read) in the chain.
module depth_chain_role (
  input  logic clk,
  input  logic rst_n,
  input  logic load_init,
  input  logic init_val,
  input  logic req,
  input  logic last,
  input  logic xin,
  output logic en,
  output logic jump,
  output logic tok,
  output logic handoff
);
  logic tok_q, tok_d;
  logic arm_q, arm_d;

  always_comb begin
    en      = req & (tok_q | arm_q);
    jump    = en & ~tok_q;
    handoff = en & last;
    if (load_init) begin
      tok_d = init_val;
    end else begin
      tok_d = (tok_q | jump) & ~handoff;
    end
    // a new pulse re-arms even in the cycle an older arm is used
    arm_d = xin | (arm_q & ~jump);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      tok_q <= tok_d;
      arm_q <= arm_d;
    end
  end

  assign tok = tok_q;
endmodule

// File: rtl/depth_chain_pulse_merge.sv
// Serialises hand-off events onto one pulse line; lower index wins.
module depth_chain_pulse_merge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] events,
  output logic         pulse
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] cur;
  logic [N-1:0] grant;
  logic         pulse_q, pulse_d;

  always_comb begin
    cur     = pend_q | events;
    grant   = cur & (~cur + 1'b1);
    pend_d  = cur & ~grant;
    pulse_d = |cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/depth_chain_ctrl.sv
module depth_chain_ctrl
  import depth_chain_pkg::*;
#(
  parameter int SYNC_STAGES = RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first_n,
  input  logic xin,
  input  logic wr_req,
  input  logic wr_last,
  input  logic rd_req,
  input  logic rd_last,
  output logic wr_en,
  output logic rd_en,
  output logic wr_jump,
  output logic rd_jump,
  output logic wr_tok,
  output logic rd_tok,
  output logic xout
);
  logic                 rst_int_n;
  logic                 ready_q;
  logic [NUM_ROLES-1:0] req_v, last_v, en_v, jump_v, tok_v, ho_v;

  depth_chain_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  // one cycle after internal release the strap is loaded into the tokens
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
    end
  end

  assign req_v[ROLE_WR]  = wr_req;
  assign req_v[ROLE_RD]  = rd_req;
  assign last_v[ROLE_WR] = wr_last;
  assign last_v[ROLE_RD] = rd_last;

  for (genvar g = 0; g < NUM_ROLES; g++) begin : g_role
    depth_chain_role u_role (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .load_init (~ready_q),
      .init_val  (~first_n),
      .req       (req_v[g]),
      .last      (last_v[g]),
      .xin       (xin),
      .en        (en_v[g]),
      .jump      (jump_v[g]),
      .tok       (tok_v[g]),
      .handoff   (ho_v[g])
    );
  end

  depth_chain_pulse_merge #(.N(NUM_ROLES)) u_merge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .events (ho_v),
    .pulse  (xout)
  );

  assign wr_en   = en_v[ROLE_WR];
  assign rd_en   = en_v[ROLE_RD];
  assign wr_jump = jump_v[ROLE_WR];
  assign rd_jump = jump_v[ROLE_RD];
  assign wr_tok  = tok_v[ROLE_WR];
  assign rd_tok  = tok_v[ROLE_RD];
endmodule

// File: rtl/depth_chain_ctrl_chk.sv
module depth_chain_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_req,
  input logic wr_last,
  input logic rd_req,
  input logic rd_last,
  input logic wr_en,
  input logic rd_en,
  input logic wr_jump,
  input logic rd_jump,
  input logic wr_tok,
  input logic rd_tok,
  input logic xout
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!wr_tok && !rd_tok && !xout && !wr_en && !rd_en));

  // R3
  wr_en_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_req);

  // R3
  rd_en_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_req);

  // R4
  wr_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_last) |=> (!wr_tok && xout));

  // R5
  rd_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_last) |=> (!rd_tok && xout));

  // R6
  dual_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_last && rd_en && rd_last) |=> xout ##1 xout);

  // R7
  wr_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_jump && !wr_last) |=> wr_tok);

  // R7
  rd_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_jump && !rd_last) |=> rd_tok);
endmodule

bind depth_chain_ctrl depth_chain_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_req  (wr_req),
  .wr_last (wr_last),
  .rd_req  (rd_req),
  .rd_last (rd_last),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .wr_jump (wr_jump),
  .rd_jump (rd_jump),
  .wr_tok  (wr_tok),
  .rd_tok  (rd_tok),
  .xout    (xout)
);

// File: tb/depth_chain_ctrl_tb.sv
module depth_chain_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, first_n, xin, wr_req, wr_last, rd_req, rd_last;
  logic wr_en, rd_en, wr_jump, rd_jump, wr_tok, rd_tok, xout;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model state
  int m_rc, m_rdy, m_wt, m_rt, m_wa, m_ra, m_pw, m_pr, m_xo;

  always #5 clk = ~clk;

  depth_chain_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .first_n(first_n), .xin(xin),
    .wr_req(wr_req), .wr_last(wr_last), .rd_req(rd_req), .rd_last(rd_last),
    .wr_en(wr_en), .rd_en(rd_en), .wr_jump(wr_jump), .rd_jump(rd_jump),
    .wr_tok(wr_tok), .rd_tok(rd_tok), .xout(xout)
  );

  task automatic model_clear();
    m_rc = 0; m_rdy = 0; m_wt = 0; m_rt = 0;
    m_wa = 0; m_ra = 0; m_pw = 0; m_pr = 0; m_xo = 0;
  endtask

  // model step on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
    end else if (m_rc < 2) begin
      m_rc = m_rc + 1;
    end else begin
      int we, re, wj, rj, wh, rh, cw, cr;
      we = wr_req && (m_wt || m_wa);
      re = rd_req && (m_rt || m_ra);
      wj = we && !m_wt;
      rj = re && !m_rt;
      wh = we && wr_last;
      rh = re && rd_last;
      if (!m_rdy) begin
        m_wt = (first_n == 0);
        m_rt = (first_n == 0);
      end else begin
        m_wt = (m_wt || wj) && !wh;
        m_rt = (m_rt || rj) && !rh;
      end
      m_wa = xin || (m_wa && !wj);
      m_ra = xin || (m_ra && !rj);
      cw = m_pw || wh;
      cr = m_pr || rh;
      m_xo = cw || cr;
      if (cw) begin
        m_pw = 0; m_pr = cr;
      end else begin
        m_pw = 0; m_pr = 0;
      end
      m_rdy = 1;
    end
  end

  task automatic chk(input string name, input logic act, input int exp);
    n_run++;
    if (act !== 1'(exp)) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%0d", tag, name, act, exp);
    end
  endtask

  task automatic compare();
    int we, re;
    if (!rst_n) begin
      we = 0; re = 0;
    end else begin
      we = wr_req && (m_wt || m_wa);
      re = rd_req && (m_rt || m_ra);
    end
    chk("wr_en", wr_en, we);
    chk("rd_en", rd_en, re);
    chk("wr_jump", wr_jump, we && !m_wt);
    chk("rd_jump", rd_jump, re && !m_rt);
    chk("wr_tok", wr_tok, m_wt);
    chk("rd_tok", rd_tok, m_rt);
    chk("xout", xout, m_xo);
  endtask

  task automatic cyc(input logic wq, input logic wl, input logic rq,
                     input logic rl, input logic x);
    @(negedge clk);
    wr_req = wq; wr_last = wl; rd_req = rq; rd_last = rl; xin = x;
    #1 compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset(input logic fst);
    @(negedge clk);
    rst_n = 1'b0; first_n = fst;
    wr_req = 0; wr_last = 0; rd_req = 0; rd_last = 0; xin = 0;
    model_clear();
    tag = "R1";
    #1 compare();
    idle(2);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);          // R1: internal release window
    tag = "R2";
    idle(2);
  endtask

  initial begin
    rst_n = 1'b0; first_n = 1'b0;
    wr_req = 0; wr_last = 0; rd_req = 0; rd_last = 0; xin = 0;
    model_clear();
    do_reset(1'b0);
    // R2 direct: first instance owns both roles
    chk("wr_tok_first", wr_tok, 1);
    chk("rd_tok_first", rd_tok, 1);

    tag = "R3";
    cyc(1, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0); cyc(1, 0, 1, 0, 0); idle(1);

    tag = "R9";
    cyc(0, 1, 0, 1, 0); cyc(0, 1, 0, 0, 0); idle(2);

    tag = "R4";
    cyc(1, 1, 0, 0, 0); idle(3);
    tag = "R8";
    cyc(1, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0); idle(1);

    tag = "R5";
    cyc(0, 0, 1, 1, 0); idle(3);
    tag = "R8";
    cyc(0, 0, 1, 1, 0); idle(2);

    tag = "R7";
    cyc(0, 0, 0, 0, 1); idle(1);
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0); idle(1);

    tag = "R6";
    cyc(1, 1, 1, 1, 0); idle(4);

    // R7 claim and hand-off in one cycle, then re-arm while arm in use
    tag = "R7";
    cyc(0, 0, 0, 0, 1);
    cyc(1, 1, 1, 0, 1);
    cyc(1, 1, 0, 0, 0); idle(3);

    // non-first instance: R2 then R8 then R7
    do_reset(1'b1);
    chk("wr_tok_other", wr_tok, 0);
    chk("rd_tok_other", rd_tok, 0);
    tag = "R8";
    cyc(1, 0, 1, 0, 0); cyc(1, 1, 1, 1, 0); idle(2);
    tag = "R7";
    cyc(0, 0, 0, 0, 1); cyc(1, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0); idle(1);

    // mixed random traffic across R3 R4 R5 R6 R7 R8 R9
    tag = "R3,R4,R5,R6,R7,R8,R9";
    for (int i = 0; i < 2000; i++) begin
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 5) == 0));
    end

    do_reset(1'b0);
    tag = "R3,R4,R5,R6,R7";
    for (int i = 0; i < 2000; i++) begin
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
          1'($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule